// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 32-bit virtual address into a 36-bit physical address by walking an in-memory translation tree. A walk starts from a context table pointer and a context number. The walker then reads the context slot and at most three further levels of table, one 32-bit word per level, over a simple memory request/acknowledge port. The two low bits of each word say whether it is empty, a pointer to a further table, a page entry or reserved. A page entry found at the first level maps 16 MB, one at the second level maps 256 KB, and one at the third level maps 4 KB.

On reaching a page entry, the walker checks the entry's used and dirty flags. If the flags need to change, it writes the updated entry back to the address it was read from before it reports the result. When translation is switched off, the virtual address passes straight through and no memory access is made. Permission checking and the storage of finished translations belong to other units, which consume the final entry and level that this block reports.

Top module: `page_walker`

## Requirements
- R1: When `mmu_enable` is 0 at the accepting edge, `done` rises in the next cycle with `xlat_off`=1, `fault`=0, `res_level`=0, `res_entry`=0 and `res_paddr` = the virtual address zero-extended to 36 bits, and `mem_req` stays 0 for the whole request.
- R2: With translation on, the first access is a read (`mem_we`=0) of address (`ctx_table_ptr`<<4) + (`ctx_num`<<4), computed in 36 bits.
- R3: Entry bits [1:0] give its kind: 0 empty, 1 table pointer, 2 page entry, 3 reserved. A table pointer read at level L (context slot = 0) leads to a read at level L+1 of (({entry[31:2],2'b00})<<4) + index, where the index is VA[31:24]*4 for level 1, VA[23:18]*4 for level 2 and VA[17:12]*4 for level 3.
- R4: A kind-0 or kind-3 entry at any level, a page entry in the context slot, or a table pointer at level 3 ends the walk with `fault`=1, `res_level` = the level of that entry, `res_entry` = that entry, `res_paddr`=0 and no write.
- R5: A page entry at level 1, 2 or 3 ends the walk with `fault`=0 and `res_paddr` = (entry[31:8]<<12) + VA[23:0], VA[17:0] or VA[11:0] respectively, truncated to 36 bits, with `res_level` = that level.
- R6: For a page entry, when the used flag (bit 5) is 0, or the request is a store and the dirty flag (bit 6) is 0, the walker writes (`mem_we`=1) to the page entry's own address the entry with bit 5 set and, for a store, bit 6 set. Otherwise it makes no write. `res_entry` carries the possibly updated entry.
- R7: `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` hold steady from the cycle a request is raised until the cycle `mem_ack` is seen, and only one access is outstanding at a time. An `mem_ack` while `mem_req` is 0 has no effect.
- R8: `done` is a one-cycle pulse, due in the cycle after the acknowledge of the walk's last access. `idle` is 1 whenever no walk is in progress, a `req_valid` raised during a walk is ignored, and the result outputs hold their values from one `done` to the next accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a walk; taken only while `idle` is 1 |
| req_vaddr | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 for a store access, 0 for a load |
| mmu_enable | input | 1 | 0 bypasses translation |
| ctx_table_ptr | input | 32 | Context table pointer (in 16-byte units) |
| ctx_num | input | CTX_W | Context number |
| idle | output | 1 | No walk in progress |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | 36 | Memory byte address of the entry |
| mem_wdata | output | 32 | Entry value to write back |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Entry word read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a bad entry |
| xlat_off | output | 1 | Result came from the bypass path |
| res_level | output | 2 | Level of the final entry (0 = context slot) |
| res_paddr | output | 36 | Translated physical address |
| res_entry | output | 32 | Final entry, after any flag update |

## Verification
A bypass request shows `done` in the cycle right after the clock edge that accepts it. During a walk, each access's `mem_ack` is consumed at the next rising edge, and `done` is due one cycle after the acknowledge of the final read or write-back. The bench drives and samples on falling edges. When it accepts a request, its model lists the accesses the walk must make. It checks each access as it acknowledges it, and marks the following falling edge as the one where `done` and the results must show. At every other falling edge it checks that `done` is low and that `mem_req` matches whether accesses are still expected. Memory latency is varied from zero to two cycles.

// File: rtl/walk_pkg.sv
// Shared constants and types for the page table walker.
// Assumes 32-bit entries, 36-bit physical addresses, three table levels
// below the context slot, and table pointers held in 16-byte units.
package walk_pkg;

    localparam int VA_W    = 32;  // virtual address width
    localparam int PA_W    = 36;  // physical address width
    localparam int ENT_W   = 32;  // table entry width
    localparam int PTR_SH  = 4;   // pointer-to-byte-address shift
    localparam int NLVL    = 3;   // table levels below the context slot
    localparam int PPN_LO  = 8;   // lowest bit of the page number field
    localparam int PAGE_SH = PPN_LO + PTR_SH; // page number to byte address

    typedef enum logic [1:0] {
        EK_NONE  = 2'd0,
        EK_TABLE = 2'd1,
        EK_PAGE  = 2'd2,
        EK_RSVD  = 2'd3
    } ent_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } walk_st_e;

    // Lowest VA bit of the table index used to leave level lvl (0..2).
    function automatic int idx_lo(input int lvl);
        return (lvl == 0) ? 24 : (lvl == 1) ? 18 : 12;
    endfunction

    // Page offset width of a page entry found at level lvl (1..3).
    function automatic int off_w(input int lvl);
        return (lvl == 1) ? 24 : (lvl == 2) ? 18 : 12;
    endfunction

endpackage

// File: rtl/walk_index.sv
// Address generator for the walker.
// Forms the context slot address from pointer and context number, and the
// address of the next-level entry from a table pointer and the VA index
// field that belongs to the level being left. Purely combinational.
module walk_index
    import walk_pkg::*;
#(
    parameter int CTX_W = 8
) (
    input  logic [VA_W-1:PAGE_SH] va_hi,     // VA bits that feed table indices
    input  logic [1:0]            lvl,       // level of the table pointer (0..2)
    input  logic [ENT_W-1:2]      desc_ptr,  // pointer field of the table entry
    input  logic [ENT_W-1:0]      ctx_ptr,
    input  logic [CTX_W-1:0]      ctx_num,
    output logic [PA_W-1:0]       ctx_addr,
    output logic [PA_W-1:0]       next_addr
);

    logic [PA_W-1:0] idx_by_lvl [NLVL];
    logic [PA_W-1:0] sel_idx;

    // One word-aligned index per level, each from its own VA field.
    for (genvar g = 0; g < NLVL; g++) begin : g_idx
        localparam int LO = idx_lo(g);
        localparam int HI = (g == 0) ? VA_W - 1 : LO + 5;
        assign idx_by_lvl[g] = PA_W'(va_hi[HI:LO]) << 2;
    end

    // Pick the index for the level being left.
    always_comb begin
        case (lvl)
            2'd0:    sel_idx = idx_by_lvl[0];
            2'd1:    sel_idx = idx_by_lvl[1];
            default: sel_idx = idx_by_lvl[2];
        endcase
    end

    // Byte addresses of the next entry and of the context slot.
    always_comb begin
        next_addr = (PA_W'({desc_ptr, 2'b00}) << PTR_SH) + sel_idx;
        ctx_addr  = (PA_W'(ctx_ptr) << PTR_SH) + (PA_W'(ctx_num) << PTR_SH);
    end

endmodule

// File: rtl/walk_leaf.sv
// Page entry evaluator for the walker.
// Given a page entry and the level it was found at (1..3), forms the
// physical address from the page number and the level's page offset. It
// also produces the entry with the used/dirty flags set as the access
// demands, and says whether a write-back is needed. Purely combinational.
module walk_leaf
    import walk_pkg::*;
#(
    parameter int ACC_BIT = 5,
    parameter int MOD_BIT = 6
) (
    input  logic [1:0]           lvl,
    input  logic [off_w(1)-1:0]  va_lo,     // VA bits that can form an offset
    input  logic [ENT_W-1:0]     ent,
    input  logic                 store,
    output logic [PA_W-1:0]      paddr,
    output logic [ENT_W-1:0]     upd_ent,
    output logic                 need_wb
);

    logic [PA_W-1:0]  off_by_lvl [NLVL];
    logic [PA_W-1:0]  sel_off;
    logic [ENT_W-1:0] set_mask;

    // Page offset for each of the three page sizes.
    for (genvar g = 1; g <= NLVL; g++) begin : g_off
        localparam int W = off_w(g);
        assign off_by_lvl[g-1] = PA_W'(va_lo[W-1:0]);
    end

    // Select the offset of the level the entry came from.
    always_comb begin
        case (lvl)
            2'd1:    sel_off = off_by_lvl[0];
            2'd2:    sel_off = off_by_lvl[1];
            default: sel_off = off_by_lvl[2];
        endcase
    end

    // Physical address and flag update.
    always_comb begin
        paddr    = (PA_W'(ent[ENT_W-1:PPN_LO]) << PAGE_SH) + sel_off;
        set_mask = '0;
        set_mask[ACC_BIT] = 1'b1;
        if (store) set_mask[MOD_BIT] = 1'b1;
        upd_ent  = ent | set_mask;
        need_wb  = !ent[ACC_BIT] || (store && !ent[MOD_BIT]);
    end

endmodule

// File: rtl/page_walker.sv
// Three-level page table walker (top).
// Accepts one translation request while idle. It either passes the address
// through (translation off) or walks context slot -> level 1 -> level 2 ->
// level 3, one memory read per level, and writes the page entry back when
// its flags change. Assumes the memory answers each request with one
// mem_ack pulse and never acknowledges unrequested accesses usefully.
// Results are registered and held until the next accepted request.
module page_walker
    import walk_pkg::*;
#(
    parameter int CTX_W   = 8,
    parameter int ACC_BIT = 5,
    parameter int MOD_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic              req_store,
    input  logic              mmu_enable,
    input  logic [ENT_W-1:0]  ctx_table_ptr,
    input  logic [CTX_W-1:0]  ctx_num,
    output logic              idle,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PA_W-1:0]   mem_addr,
    output logic [ENT_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              done,
    output logic              fault,
    output logic              xlat_off,
    output logic [1:0]        res_level,
    output logic [PA_W-1:0]   res_paddr,
    output logic [ENT_W-1:0]  res_entry
);

    localparam logic [1:0] LAST_LVL = 2'(NLVL);

    walk_st_e         state_q;
    logic [1:0]       lvl_q;
    logic [VA_W-1:0]  va_q;
    logic             store_q;
    logic [PA_W-1:0]  addr_q;
    logic [ENT_W-1:0] wdata_q;

    logic [PA_W-1:0]  ctx_addr;
    logic [PA_W-1:0]  next_addr;
    logic [PA_W-1:0]  leaf_paddr;
    logic [ENT_W-1:0] leaf_ent;
    logic             leaf_wb;
    ent_kind_e        kind;

    walk_index #(.CTX_W(CTX_W)) u_index (
        .va_hi     (va_q[VA_W-1:PAGE_SH]),
        .lvl       (lvl_q),
        .desc_ptr  (mem_rdata[ENT_W-1:2]),
        .ctx_ptr   (ctx_table_ptr),
        .ctx_num   (ctx_num),
        .ctx_addr  (ctx_addr),
        .next_addr (next_addr)
    );

    walk_leaf #(.ACC_BIT(ACC_BIT), .MOD_BIT(MOD_BIT)) u_leaf (
        .lvl     (lvl_q),
        .va_lo   (va_q[off_w(1)-1:0]),
        .ent     (mem_rdata),
        .store   (store_q),
        .paddr   (leaf_paddr),
        .upd_ent (leaf_ent),
        .need_wb (leaf_wb)
    );

    // Memory port and status decoded from the walk state.
    always_comb begin
        kind      = ent_kind_e'(mem_rdata[1:0]);
        idle      = (state_q == ST_IDLE);
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_WRITE);
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
    end

    // Walk sequencer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            lvl_q     <= '0;
            va_q      <= '0;
            store_q   <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            done      <= 1'b0;
            fault     <= 1'b0;
            xlat_off  <= 1'b0;
            res_level <= '0;
            res_paddr <= '0;
            res_entry <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        store_q <= req_store;
                        lvl_q   <= '0;
                        if (!mmu_enable) begin
                            done      <= 1'b1;
                            fault     <= 1'b0;
                            xlat_off  <= 1'b1;
                            res_level <= '0;
                            res_entry <= '0;
                            res_paddr <= PA_W'(req_vaddr);
                        end else begin
                            addr_q  <= ctx_addr;
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (kind == EK_TABLE && lvl_q != LAST_LVL) begin
                            addr_q <= next_addr;
                            lvl_q  <= lvl_q + 2'd1;
                        end else if (kind == EK_PAGE && lvl_q != 2'd0) begin
                            fault     <= 1'b0;
                            xlat_off  <= 1'b0;
                            res_level <= lvl_q;
                            res_paddr <= leaf_paddr;
                            res_entry <= leaf_ent;
                            if (leaf_wb) begin
                                wdata_q <= leaf_ent;
                                state_q <= ST_WRITE;
                            end else begin
                                done    <= 1'b1;
                                state_q <= ST_IDLE;
                            end
                        end else begin
                            fault     <= 1'b1;
                            xlat_off  <= 1'b0;
                            res_level <= lvl_q;
                            res_paddr <= '0;
                            res_entry <= mem_rdata;
                            done      <= 1'b1;
                            state_q   <= ST_IDLE;
                        end
                    end
                end
                ST_WRITE: begin
                    if (mem_ack) begin
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr)
                                && $stable(mem_we) && $stable(mem_wdata));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    wb_same_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |-> $stable(mem_addr));

    // R1
    bypass_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && xlat_off |-> !fault && !mem_req);

    // R4
    fault_no_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && fault |-> res_paddr == '0 && !xlat_off);

endmodule

// File: tb/page_walker_tb.sv
module page_walker_tb;

    localparam int CTX_W = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic        mmu_enable = 1'b0;
    logic [31:0] ctx_table_ptr = '0;
    logic [CTX_W-1:0] ctx_num = '0;
    logic        idle, mem_req, mem_we, done, fault, xlat_off;
    logic [35:0] mem_addr, res_paddr;
    logic [31:0] mem_wdata, res_entry;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [1:0]  res_level;

    always #2 clk = ~clk;   // 250 MHz

    page_walker #(.CTX_W(CTX_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .mmu_enable(mmu_enable),
        .ctx_table_ptr(ctx_table_ptr), .ctx_num(ctx_num), .idle(idle),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .done(done), .fault(fault), .xlat_off(xlat_off), .res_level(res_level),
        .res_paddr(res_paddr), .res_entry(res_entry)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [31:0] mem [logic [35:0]];

    // expected accesses of the current walk
    logic [35:0] q_addr [$];
    bit          q_we [$];
    logic [31:0] q_data [$];

    // expected result
    bit          e_fault, e_off, have_res;
    logic [1:0]  e_lvl;
    logic [35:0] e_pa;
    logic [31:0] e_ent;
    string       cur_tag = "";

    bit m_busy = 0;
    bit due_next = 0;
    bit due_now;
    bit stray_req = 0;
    int lat_cnt = 0;
    int nserve = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [35:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mk_desc(input logic [35:0] base);
        return {base[35:6], 2'b01};
    endfunction

    function automatic logic [31:0] mk_pte(input logic [23:0] ppn, input bit a, input bit m);
        return {ppn, 1'b0, m, a, 3'b000, 2'b10};
    endfunction

    function automatic logic [35:0] lvl_index(input int lvl, input logic [31:0] va);
        if (lvl == 1) return {26'd0, va[31:24], 2'b00};
        if (lvl == 2) return {28'd0, va[23:18], 2'b00};
        return {28'd0, va[17:12], 2'b00};
    endfunction

    // Behavioural model: list the walk's accesses and its result.
    task automatic model_walk(input logic [31:0] va, input bit st, input bit en,
                              input logic [31:0] ptr, input logic [CTX_W-1:0] cn);
        logic [35:0] a;
        logic [31:0] e, nu;
        logic [35:0] off;
        int lvl;
        bit fin;
        q_addr.delete(); q_we.delete(); q_data.delete();
        e_off = !en;
        if (!en) begin
            e_fault = 0; e_lvl = 0; e_pa = {4'd0, va}; e_ent = 0;
            due_next = 1;
            return;
        end
        a = ({4'd0, ptr} << 4) + (36'(cn) << 4);
        lvl = 0;
        fin = 0;
        while (!fin) begin
            e = rd(a);
            q_addr.push_back(a); q_we.push_back(0); q_data.push_back(32'h0);
            if (e[1:0] == 2'd1 && lvl < 3) begin
                lvl = lvl + 1;
                a = ({4'd0, e[31:2], 2'b00} << 4) + lvl_index(lvl, va);
            end else if (e[1:0] == 2'd2 && lvl >= 1) begin
                off = (lvl == 1) ? 36'(va[23:0]) : (lvl == 2) ? 36'(va[17:0]) : 36'(va[11:0]);
                e_pa = (36'(e[31:8]) << 12) + off;
                nu = e | 32'h20 | (st ? 32'h40 : 32'h0);
                if (nu != e) begin
                    q_addr.push_back(a); q_we.push_back(1); q_data.push_back(nu);
                end
                e_fault = 0; e_lvl = 2'(lvl); e_ent = nu;
                fin = 1;
            end else begin
                e_fault = 1; e_lvl = 2'(lvl); e_ent = e; e_pa = 0;
                fin = 1;
            end
        end
    endtask

    // Accept requests exactly as the interface rule says.
    always @(posedge clk) begin
        if (rst_n && req_valid && !m_busy) begin
            m_busy = 1;
            model_walk(req_vaddr, req_store, mmu_enable, ctx_table_ptr, ctx_num);
        end
    end

    // Per-cycle comparison and memory responder.
    always @(negedge clk) begin
        if (rst_n) begin
            due_now = due_next;
            due_next = 0;
            chk(done == due_now, "R8 done timing", 64'(done), 64'(due_now));
            if (due_now) begin
                chk(fault == e_fault, {cur_tag, " fault"}, 64'(fault), 64'(e_fault));
                chk(xlat_off == e_off, {cur_tag, " xlat_off"}, 64'(xlat_off), 64'(e_off));
                chk(res_level == e_lvl, {cur_tag, " level"}, 64'(res_level), 64'(e_lvl));
                chk(res_paddr == e_pa, {cur_tag, " paddr"}, 64'(res_paddr), 64'(e_pa));
                chk(res_entry == e_ent, {cur_tag, " entry"}, 64'(res_entry), 64'(e_ent));
                have_res = 1;
                m_busy = 0;
            end else if (!m_busy) begin
                chk(idle == 1'b1, "R8 idle", 64'(idle), 64'd1);
                if (have_res)
                    chk(res_paddr == e_pa && res_entry == e_ent && fault == e_fault,
                        "R8 hold", 64'(res_paddr), 64'(e_pa));
            end
            chk(mem_req == (q_addr.size() != 0), "R7 request presence",
                64'(mem_req), 64'(q_addr.size() != 0));
            if (mem_ack) begin
                mem_ack = 0;
            end else if (mem_req && q_addr.size() != 0) begin
                if (lat_cnt == 0) begin
                    chk(mem_addr == q_addr[0], q_we[0] ? "R6 write addr" : "R3 read addr",
                        64'(mem_addr), 64'(q_addr[0]));
                    chk(mem_we == q_we[0], "R6 access kind", 64'(mem_we), 64'(q_we[0]));
                    if (q_we[0]) begin
                        chk(mem_wdata == q_data[0], "R6 write data",
                            64'(mem_wdata), 64'(q_data[0]));
                        mem[mem_addr] = mem_wdata;
                    end else begin
                        mem_rdata = rd(mem_addr);
                    end
                    mem_ack = 1;
                    void'(q_addr.pop_front()); void'(q_we.pop_front()); void'(q_data.pop_front());
                    if (q_addr.size() == 0) due_next = 1;
                    nserve++;
                    lat_cnt = nserve % 3;
                end else begin
                    lat_cnt--;
                end
            end else if (stray_req && !mem_req) begin
                mem_ack = 1;
                mem_rdata = 32'hFFFF_FFFF;
                stray_req = 0;
            end
        end
    end

    task automatic run(input string tag, input logic [31:0] va, input bit st,
                       input bit en, input logic [31:0] ptr,
                       input logic [CTX_W-1:0] cn, input bit poke);
        int guard;
        @(negedge clk);
        cur_tag = tag;
        req_vaddr = va; req_store = st; mmu_enable = en;
        ctx_table_ptr = ptr; ctx_num = cn; req_valid = 1;
        @(negedge clk);
        req_valid = 0;
        if (poke) begin
            @(negedge clk);
            req_vaddr = 32'hDEAD_0000; mmu_enable = 0; req_valid = 1;
            @(negedge clk);
            req_valid = 0;
        end
        guard = 0;
        while (m_busy && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
        repeat (2) @(negedge clk);
    endtask

    localparam logic [31:0] PTR = 32'h0001_0000;        // context table at 0x10_0000
    localparam logic [35:0] CT  = 36'h0_0010_0000;
    localparam logic [35:0] L1A = 36'h0_0020_0000;
    localparam logic [35:0] L2A = 36'h0_0030_0000;
    localparam logic [35:0] L3A = 36'h0_0040_0000;
    localparam logic [35:0] L1B = 36'h0_0050_0000;
    localparam logic [31:0] VA1 = 32'h1234_5678;
    localparam logic [31:0] VA2 = 32'h5500_0123;
    localparam logic [31:0] VA3 = 32'h1240_0456;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(idle && !done && !mem_req && res_paddr == 0 && !fault,
            "R8 reset state", {idle, done, mem_req, fault}, 64'h8);

        // table setup
        mem[CT + 36'h30] = mk_desc(L1A);                          // context 3
        mem[CT + 36'h40] = mk_desc(L1B);                          // context 4
        mem[CT + 36'h60] = mk_pte(24'h000111, 1, 1);              // context 6: page in slot
        mem[L1A + lvl_index(1, VA1)] = mk_desc(L2A);
        mem[L2A + lvl_index(2, VA1)] = mk_desc(L3A);
        mem[L3A + lvl_index(3, VA1)] = mk_pte(24'hABCDE1, 1, 1);
        mem[L1A + lvl_index(1, VA2)] = mk_pte(24'h000700, 0, 0);
        mem[L2A + lvl_index(2, VA3)] = mk_pte(24'h0123F0, 1, 1);
        mem[L1A + lvl_index(1, 32'h7700_0000)] = 32'h0000_0003;
        mem[L3A + lvl_index(3, 32'h1234_A000)] = mk_desc(L3A);
        mem[L1B + lvl_index(1, VA1)] = mk_pte(24'h000C00, 1, 1);

        run("R1 bypass load", 32'h89AB_CDEF, 0, 0, PTR, 3, 0);
        run("R1 bypass store", 32'h0000_0FFF, 1, 0, PTR, 3, 0);
        run("R5 4KB load no write", VA1, 0, 1, PTR, 3, 0);
        mem[L3A + lvl_index(3, VA1)] = mk_pte(24'hABCDE1, 1, 0);
        run("R6 4KB store sets dirty", VA1, 1, 1, PTR, 3, 0);
        run("R6 4KB store already dirty", VA1, 1, 1, PTR, 3, 0);
        run("R6 16MB load sets used", VA2, 0, 1, PTR, 3, 0);
        run("R5 16MB load after update", VA2, 0, 1, PTR, 3, 0);
        run("R5 256KB load", VA3, 0, 1, PTR, 3, 0);
        mem[L2A + lvl_index(2, VA3)] = mk_pte(24'h0123F0, 0, 0);
        run("R6 256KB store sets both", VA3, 1, 1, PTR, 3, 0);
        run("R2 other context", VA1, 0, 1, PTR, 4, 0);
        run("R4 empty context slot", VA1, 0, 1, PTR, 5, 0);
        run("R4 page in context slot", VA1, 0, 1, PTR, 6, 0);
        run("R4 reserved level 1", 32'h7700_0000, 0, 1, PTR, 3, 0);
        run("R4 empty level 2", 32'h1280_0000, 0, 1, PTR, 3, 0);
        run("R4 table at level 3", 32'h1234_A000, 1, 1, PTR, 3, 0);
        run("R8 request during walk", VA1, 0, 1, PTR, 3, 1);

        // R7: acknowledge with no request outstanding must change nothing
        @(negedge clk);
        stray_req = 1;
        repeat (4) @(negedge clk);
        chk(idle && !mem_req && !done && res_paddr == e_pa && res_entry == e_ent,
            "R7 stray ack", 64'(res_paddr), 64'(e_pa));
        run("R3 walk after stray ack", VA1, 0, 1, PTR, 3, 0);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule